// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is an 8-bit special-function register that a small CPU core uses to start and stop two timers and to collect requests from two active-low external interrupt pins. Software reaches it over a simple SFR port, either by whole-byte writes or by single-bit set and clear operations. Timer overflow pulses and falling edges on the pins set request flags. A vector-acknowledge input clears the matching flag when the CPU enters the service routine.

Each external pin can be set to falling-edge or low-level sensing. In edge mode the flag is latched and cleared by the acknowledge or by software. In level mode the flag follows the synchronized pin, and neither the acknowledge nor software changes it. The timer counters and interrupt priority logic are outside this block. The timer-run, timer-flag and external-flag outputs feed them.

Top module: `tmr_irq_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00 at address 0x88. Reads at any other address return 0x00.
- R2: Bit layout, bit 7 down to bit 0: timer-1 flag, timer-1 run, timer-0 flag, timer-0 run, ext-1 flag, ext-1 mode, ext-0 flag, ext-0 mode. A mode bit of 1 selects edge sensing and 0 selects level sensing.
- R3: A pulse on `tmr_ovf_i[n]` sets timer flag n on the next clock edge. In the same cycle it wins over the acknowledge and over a software write.
- R4: `tmr_ack_i[n]` clears timer flag n. In the same cycle it wins over a software write of 1.
- R5: Timer run bits change only through software writes, and `tmr_run_o` reflects them.
- R6: In edge mode a falling edge on `ext_irq_ni[n]` sets ext flag n, at most three clock edges after the pin falls. `ext_ack_i[n]` or a software write of 0 clears the flag. A pin held low does not set it again.
- R7: In level mode ext flag n reads 1 exactly while the synchronized pin is low. The acknowledge has no effect on it, and neither do software writes to it.
- R8: A bit-set or bit-clear access (`sfr_bit_sel_i` selects bit 0..7) changes only the selected bit.
- R9: Writes and bit accesses to any address other than 0x88 leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wr_i | input | 1 | Byte write strobe |
| sfr_wdata_i | input | 8 | Byte write data |
| sfr_bit_set_i | input | 1 | Set selected bit |
| sfr_bit_clr_i | input | 1 | Clear selected bit |
| sfr_bit_sel_i | input | 3 | Bit index for bit access |
| sfr_rdata_o | output | 8 | Read data (0 when address does not match) |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| tmr_ack_i | input | 2 | Timer vector acknowledge |
| ext_irq_ni | input | 2 | External interrupt pins, active low |
| ext_ack_i | input | 2 | External interrupt vector acknowledge |
| tmr_run_o | output | 2 | Timer run enables |
| tmr_flag_o | output | 2 | Timer interrupt requests |
| ext_flag_o | output | 2 | External interrupt requests |

## Verification
The assertions assume that the pins are held high while reset is asserted and for two clocks after it. The synchronizer latency check counts only from that point. They also assume that at most one SFR access strobe (byte write, bit set or bit clear) is active in any cycle. The bench drives every input on the falling clock edge. It keeps the pins high through reset and never raises two access strobes together. Pins change only with at least three clocks between transitions, so every edge passes through the synchronizer cleanly.

// File: rtl/tcon_pkg.sv
package tcon_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SEL_W  = $clog2(DATA_W);

  // bit positions per channel; a CPU core decodes these
  function automatic int unsigned tf_pos(input int unsigned n); return 5 + 2 * n; endfunction
  function automatic int unsigned tr_pos(input int unsigned n); return 4 + 2 * n; endfunction
  function automatic int unsigned ie_pos(input int unsigned n); return 1 + 2 * n; endfunction
  function automatic int unsigned it_pos(input int unsigned n); return 2 * n; endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pin_s_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];

  // latency check armed once two clocks have passed since reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  p_sync_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STAGES == 2 && age_q == 2'd2) |-> pin_s_o == $past(pin_ni, 2));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic ack_i,
  input  logic run_we_i,
  input  logic run_wd_i,
  input  logic flag_we_i,
  input  logic flag_wd_i,
  output logic run_o,
  output logic flag_o
);
  logic run_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (run_we_i) run_q <= run_wd_i;
      if (ovf_i)          flag_q <= 1'b1;   // hardware set wins
      else if (ack_i)     flag_q <= 1'b0;
      else if (flag_we_i) flag_q <= flag_wd_i;
    end
  end

  assign run_o  = run_q;
  assign flag_o = flag_q;

  p_ovf_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_o);
  p_ack_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ovf_i) |=> !flag_o);
  p_run_sw_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_we_i |=> $stable(run_o));
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic ack_i,
  input  logic mode_we_i,
  input  logic mode_wd_i,
  input  logic flag_we_i,
  input  logic flag_wd_i,
  output logic mode_o,
  output logic flag_o
);
  logic pin_s, fall;
  logic mode_q, edge_q;

  irq_pin_sync #(.STAGES(2)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_ni  (pin_ni),
    .pin_s_o (pin_s),
    .fall_o  (fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_wd_i;
      if (!mode_q)        edge_q <= 1'b0;   // latch idle in level mode
      else if (fall)      edge_q <= 1'b1;
      else if (ack_i)     edge_q <= 1'b0;
      else if (flag_we_i) edge_q <= flag_wd_i;
    end
  end

  assign mode_o = mode_q;
  assign flag_o = mode_q ? edge_q : ~pin_s;

  p_edge_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && fall && !mode_we_i) |=> flag_o);
  p_edge_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !fall && ack_i && !mode_we_i) |=> !flag_o);
endmodule

// File: rtl/tmr_irq_ctrl_reg.sv
module tmr_irq_ctrl_reg
  import tcon_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h88,
  parameter int unsigned       NUM_CH   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  input  logic              sfr_bit_set_i,
  input  logic              sfr_bit_clr_i,
  input  logic [SEL_W-1:0]  sfr_bit_sel_i,
  output logic [DATA_W-1:0] sfr_rdata_o,
  input  logic [1:0]        tmr_ovf_i,
  input  logic [1:0]        tmr_ack_i,
  input  logic [1:0]        ext_irq_ni,
  input  logic [1:0]        ext_ack_i,
  output logic [1:0]        tmr_run_o,
  output logic [1:0]        tmr_flag_o,
  output logic [1:0]        ext_flag_o
);
  logic              hit;
  logic [DATA_W-1:0] sw_we, sw_wd, reg_val;
  logic [1:0]        ext_mode;

  assign hit = (sfr_addr_i == REG_ADDR);

  always_comb begin
    sw_we = '0;
    sw_wd = '0;
    if (hit && sfr_wr_i) begin
      sw_we = '1;
      sw_wd = sfr_wdata_i;
    end else if (hit && sfr_bit_set_i) begin
      sw_we[sfr_bit_sel_i] = 1'b1;
      sw_wd[sfr_bit_sel_i] = 1'b1;
    end else if (hit && sfr_bit_clr_i) begin
      sw_we[sfr_bit_sel_i] = 1'b1;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    tmr_chan i_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ovf_i     (tmr_ovf_i[n]),
      .ack_i     (tmr_ack_i[n]),
      .run_we_i  (sw_we[tr_pos(n)]),
      .run_wd_i  (sw_wd[tr_pos(n)]),
      .flag_we_i (sw_we[tf_pos(n)]),
      .flag_wd_i (sw_wd[tf_pos(n)]),
      .run_o     (tmr_run_o[n]),
      .flag_o    (tmr_flag_o[n])
    );

    ext_irq_chan i_ext (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_ni    (ext_irq_ni[n]),
      .ack_i     (ext_ack_i[n]),
      .mode_we_i (sw_we[it_pos(n)]),
      .mode_wd_i (sw_wd[it_pos(n)]),
      .flag_we_i (sw_we[ie_pos(n)]),
      .flag_wd_i (sw_wd[ie_pos(n)]),
      .mode_o    (ext_mode[n]),
      .flag_o    (ext_flag_o[n])
    );

    assign reg_val[tf_pos(n)] = tmr_flag_o[n];
    assign reg_val[tr_pos(n)] = tmr_run_o[n];
    assign reg_val[ie_pos(n)] = ext_flag_o[n];
    assign reg_val[it_pos(n)] = ext_mode[n];
  end

  assign sfr_rdata_o = hit ? reg_val : '0;

  p_bit_set_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !sfr_wr_i && sfr_bit_set_i && sfr_bit_sel_i == SEL_W'(tr_pos(0))) |=> tmr_run_o[0]);
  p_bit_clr_keeps_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !sfr_wr_i && !sfr_bit_set_i && sfr_bit_clr_i && sfr_bit_sel_i != SEL_W'(tr_pos(1)))
      |=> $stable(tmr_run_o[1]));
  p_miss_keeps_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(tmr_run_o));
endmodule

// File: tb/test_tmr_irq_ctrl_reg.sv
module test_tmr_irq_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h88;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       bset = 1'b0, bclr = 1'b0;
  logic [2:0] bsel = '0;
  logic [7:0] rdata;
  logic [1:0] ovf = '0, tack = '0, pins = 2'b11, eack = '0;
  logic [1:0] run, tflag, eflag;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_irq_ctrl_reg i_tmr_irq_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .sfr_addr_i(addr), .sfr_wr_i(wr),
    .sfr_wdata_i(wdata), .sfr_bit_set_i(bset), .sfr_bit_clr_i(bclr),
    .sfr_bit_sel_i(bsel), .sfr_rdata_o(rdata), .tmr_ovf_i(ovf),
    .tmr_ack_i(tack), .ext_irq_ni(pins), .ext_ack_i(eack),
    .tmr_run_o(run), .tmr_flag_o(tflag), .ext_flag_o(eflag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0; addr = 8'h88;
  endtask

  task automatic bit_op(input bit set, input logic [2:0] sel);
    bsel = sel; bset = set; bclr = !set;
    tick();
    bset = 1'b0; bclr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset value", rdata, 8'h00);
    chk("R1 reset outputs", {2'b0, run, tflag, eflag}, 8'h00);
    addr = 8'h8A;
    chk("R1 other address reads zero", rdata, 8'h00);
    addr = 8'h88;
  endtask

  task automatic t_run;
    wr_byte(8'h88, 8'h50);
    chk("R5 run bits written", {6'b0, run}, 8'h03);
    chk("R2 run bits layout", rdata, 8'h50);
    wr_byte(8'h88, 8'h10);
    chk("R5 run1 stopped", {6'b0, run}, 8'h01);
  endtask

  task automatic t_tmr_flags;
    ovf = 2'b01; tick(); ovf = '0;
    chk("R3 ovf0 sets flag", rdata, 8'h30);
    ovf = 2'b10; tick(); ovf = '0;
    chk("R3 ovf1 sets flag", rdata, 8'hB0);
    chk("R3 flag outputs", {6'b0, tflag}, 8'h03);
    tack = 2'b01; tick(); tack = '0;
    chk("R4 ack0 clears flag", rdata, 8'h90);
    ovf = 2'b01; tack = 2'b01; tick(); ovf = '0; tack = '0;
    chk("R3 ovf beats ack", rdata, 8'hB0);
    tack = 2'b10; bsel = 3'd7; bset = 1'b1; tick(); tack = '0; bset = 1'b0;
    chk("R4 ack beats sw set", rdata, 8'h30);
    ovf = 2'b10; addr = 8'h88; wdata = 8'h00; wr = 1'b1; tick(); wr = 1'b0; ovf = '0;
    chk("R3 ovf beats sw write", rdata, 8'h80);
    wr_byte(8'h88, 8'h00);
  endtask

  task automatic t_bit_ops;
    bit_op(1, 3'd6);
    chk("R8 set bit6 only", rdata, 8'h40);
    chk("R8 run1 from bit set", {6'b0, run}, 8'h02);
    bit_op(1, 3'd0);
    chk("R8 set bit0 only", rdata, 8'h41);
    bit_op(0, 3'd6);
    chk("R8 clear bit6 only", rdata, 8'h01);
    wr_byte(8'h88, 8'h00);
  endtask

  task automatic t_edge;
    wr_byte(8'h88, 8'h01);
    pins[0] = 1'b0; tick(3);
    chk("R6 falling edge sets ext0 flag", rdata, 8'h03);
    eack = 2'b01; tick(); eack = '0;
    chk("R6 ack clears ext0 flag", rdata, 8'h01);
    tick(3);
    chk("R6 held low no reset of flag", rdata, 8'h01);
    pins[0] = 1'b1; tick(3);
    pins[0] = 1'b0; tick(3);
    chk("R6 second edge sets flag", rdata, 8'h03);
    bit_op(0, 3'd1);
    chk("R6 sw clear in edge mode", rdata, 8'h01);
    pins[0] = 1'b1; tick(3);
    wr_byte(8'h88, 8'h00);
  endtask

  task automatic t_level;
    pins[1] = 1'b0; tick(3);
    chk("R7 level low reads flag", rdata, 8'h08);
    chk("R7 ext flag output", {6'b0, eflag}, 8'h02);
    eack = 2'b10; tick(); eack = '0;
    chk("R7 ack ignored in level mode", rdata, 8'h08);
    bit_op(0, 3'd3);
    chk("R7 sw clear ignored in level mode", rdata, 8'h08);
    pins[1] = 1'b1; tick(3);
    chk("R7 pin high clears flag", rdata, 8'h00);
    bit_op(1, 3'd3);
    chk("R7 sw set ignored in level mode", rdata, 8'h00);
  endtask

  task automatic t_other_addr;
    wr_byte(8'h89, 8'hFF);
    chk("R9 foreign write ignored", rdata, 8'h00);
    addr = 8'h89; bsel = 3'd4; bset = 1'b1; tick(); bset = 1'b0;
    chk("R1 foreign address reads zero", rdata, 8'h00);
    addr = 8'h88;
    chk("R9 foreign bit set ignored", rdata, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_run();
    t_tmr_flags();
    t_bit_ops();
    t_edge();
    t_level();
    t_other_addr();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule